// File: doc/BRIEF.md
# Wide-to-Byte External Bus Bridge

This block sits as a slave on a 32-bit memory-mapped host bus with four byte enables. It drives a shared, asynchronous, 8-bit external bus that serves several peripherals. Each host transfer becomes a run of single-byte external cycles. There is exactly one cycle for each asserted byte enable, and lanes that are not enabled are never touched. A register that clears when read is therefore never disturbed by a read of a neighbouring byte. The host is held on a wait signal until the last byte cycle has ended. Read bytes are placed in their own lanes, and lanes that were not enabled return zero.

The mapping is dense: four consecutive external bytes form one host word, with the lowest byte in lane 0. The host word address selects one of several devices, each with a 1 MiB window, and supplies the upper external address bits. The bridge adds the two low bits from the lane being served. Each byte cycle has a setup phase, a strobe phase and a hold phase, and their lengths in clocks are parameters. The active-low interrupt line of each device is synchronised and passed to the host as an active-high flag.

The controller has five states. In ST_IDLE it waits for a request. It goes to ST_SETUP when at least one lane is enabled, and to ST_DONE when no lane is enabled. The phases run in order ST_SETUP to ST_STROBE to ST_HOLD, and each phase leaves when its timer expires. From ST_HOLD the controller goes back to ST_SETUP for the next enabled lane, or on to ST_DONE after the last one. ST_DONE lasts one cycle, in which the wait signal is low, and then returns to ST_IDLE.

Top module: `wide_byte_bridge`

## Requirements
- R1: A host transfer produces exactly one external strobe for each bit set in `h_be`, and none for a cleared bit. With `h_be` all zero the transfer completes with no external cycle.
- R2: During a byte cycle, `ext_addr[1:0]` equals the lane index (lane k carries host bits 8k+7..8k). `ext_addr[19:2]` equals `h_waddr[17:0]`.
- R3: Device d is chosen by `h_waddr[19:18]`. Only `ext_cs_n[d]` is low, and only during setup, strobe and hold. At all other times every chip select is high.
- R4: Byte cycles of one transfer run in ascending lane order.
- R5: Each byte cycle has SETUP_CYC clocks with the chip select low and the strobe high, then STROBE_CYC clocks with the strobe low, then HOLD_CYC clocks with the strobe high again. The read and write strobes are never low together, and the address is steady while a strobe is low.
- R6: `h_wait` is high while a request is held, from its first cycle until the controller reaches ST_DONE. That takes popcount(`h_be`) x (SETUP_CYC+STROBE_CYC+HOLD_CYC) clocks after acceptance. In the following cycle `h_wait` is low and the transfer completes.
- R7: On a read, `ext_din` is sampled at the clock edge that ends the strobe phase and is placed in lane `ext_addr[1:0]` of `h_rdata`. Lanes that were not enabled read as zero.
- R8: On a write (`h_write`, which wins over `h_read`), `ext_dout` carries the matching lane of `h_wdata`. `ext_doe` is high only from setup through hold of a write cycle, and it is low after reset and on reads.
- R9: `h_irq[i]` equals `~ext_irq_n[i]` after a two-flop synchroniser. A change shows on `h_irq` after the second rising clock edge and not after the first.
- R10: After reset, every chip select and both strobes are high, `ext_doe` is low, `h_wait` is low with no request, and `h_irq` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_waddr | input | 20 | Host word address: device select in bits 19:18, upper external address in bits 17:0 |
| h_be | input | 4 | Host byte enables, one per lane |
| h_read | input | 1 | Read request, held until `h_wait` is low |
| h_write | input | 1 | Write request, held until `h_wait` is low |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Assembled read data, valid in the cycle `h_wait` is low |
| h_wait | output | 1 | Wait request to the host |
| h_irq | output | 4 | Synchronised active-high interrupt flags |
| ext_addr | output | 20 | Shared external byte address |
| ext_dout | output | 8 | External data to the pad driver |
| ext_din | input | 8 | External data from the pad |
| ext_doe | output | 1 | Pad driver enable; high impedance when low |
| ext_rd_n | output | 1 | Shared active-low read strobe |
| ext_wr_n | output | 1 | Shared active-low write strobe |
| ext_cs_n | output | 4 | Active-low chip select, one per device |
| ext_irq_n | input | 4 | Active-low interrupt, one per device |

## Verification
Random reads and writes are run with all sixteen byte-enable patterns, random devices and random word addresses. Directed cases cover single lanes, both halfwords, the full word, the empty mask and the split mask 1001. Single-lane patterns show whether the low address bits and read-lane placement follow the enabled bit. The split and empty masks expose a bridge that walks a fixed lane range or touches unselected lanes, which is caught by the strobe count, the lane order and the unchanged neighbouring bytes. Counting wait cycles and chip-select cycles against the phase lengths separates correct sequencing from an off-by-one phase timer.

// File: rtl/bytebus_pkg.sv
package bytebus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } bb_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/bb_lane_pick.sv
module bb_lane_pick #(
    parameter int LANES = 4,
    localparam int IW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0] mask,
    output logic             any,
    output logic [IW-1:0]    idx
);

    always_comb begin
        any = |mask;
        idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (mask[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/bb_phase_timer.sv
module bb_phase_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/bb_irq_sync.sv
module bb_irq_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_n,
    output logic [N-1:0] flag
);

    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
        end else begin
            meta_q <= line_n;
            sync_q <= meta_q;
        end
    end

    assign flag = ~sync_q;

endmodule

// File: rtl/wide_byte_bridge.sv
module wide_byte_bridge
    import bytebus_pkg::*;
#(
    parameter int HOST_DW    = 32,
    parameter int EXT_AW     = 20,
    parameter int DEV_W      = 2,
    parameter int SETUP_CYC  = 1,
    parameter int STROBE_CYC = 2,
    parameter int HOLD_CYC   = 1
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [EXT_AW+DEV_W-$clog2(HOST_DW/8)-1:0] h_waddr,
    input  logic [HOST_DW/8-1:0]                    h_be,
    input  logic                                    h_read,
    input  logic                                    h_write,
    input  logic [HOST_DW-1:0]                      h_wdata,
    output logic [HOST_DW-1:0]                      h_rdata,
    output logic                                    h_wait,
    output logic [(1<<DEV_W)-1:0]                   h_irq,
    output logic [EXT_AW-1:0]                       ext_addr,
    output logic [7:0]                              ext_dout,
    input  logic [7:0]                              ext_din,
    output logic                                    ext_doe,
    output logic                                    ext_rd_n,
    output logic                                    ext_wr_n,
    output logic [(1<<DEV_W)-1:0]                   ext_cs_n,
    input  logic [(1<<DEV_W)-1:0]                   ext_irq_n
);

    localparam int LANES  = HOST_DW / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int NDEV   = 1 << DEV_W;
    localparam int UPA_W  = EXT_AW - LANE_W;
    localparam int MAXPH  = max3(SETUP_CYC, STROBE_CYC, HOLD_CYC);
    localparam int CNT_W  = (MAXPH > 1) ? $clog2(MAXPH) : 1;
    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);

    bb_state_e st_q, st_d;

    logic              req;
    logic              wr_q;
    logic [UPA_W-1:0]  addr_q;
    logic [DEV_W-1:0]  dev_q;
    logic [HOST_DW-1:0] wdata_q;
    logic [HOST_DW-1:0] rdata_q;
    logic [LANES-1:0]  pend_q;
    logic [LANE_W-1:0] lane_q;
    logic [LANES-1:0]  lane_oh;
    logic [LANES-1:0]  pick_in;
    logic              pick_any;
    logic [LANE_W-1:0] pick_idx;
    logic              tmr_ld;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              take;
    logic              adv;
    logic              capture;
    logic              active;

    assign req     = h_read | h_write;
    assign lane_oh = LANES'(1) << lane_q;
    assign pick_in = (st_q == ST_IDLE) ? h_be : (pend_q & ~lane_oh);

    bb_lane_pick #(.LANES(LANES)) u_pick (
        .mask (pick_in),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    bb_phase_timer #(.CW(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_ld),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    bb_irq_sync #(.N(NDEV)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_n (ext_irq_n),
        .flag   (h_irq)
    );

    // next state and sequencing strobes
    always_comb begin
        st_d    = st_q;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        take    = 1'b0;
        adv     = 1'b0;
        capture = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req) begin
                    take = 1'b1;
                    if (pick_any) begin
                        st_d    = ST_SETUP;
                        tmr_ld  = 1'b1;
                        tmr_val = SETUP_LD;
                    end else begin
                        st_d = ST_DONE;
                    end
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    st_d    = ST_STROBE;
                    tmr_ld  = 1'b1;
                    tmr_val = STROBE_LD;
                end
            end
            ST_STROBE: begin
                if (tmr_done) begin
                    st_d    = ST_HOLD;
                    tmr_ld  = 1'b1;
                    tmr_val = HOLD_LD;
                    capture = ~wr_q;
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    adv = 1'b1;
                    if (pick_any) begin
                        st_d    = ST_SETUP;
                        tmr_ld  = 1'b1;
                        tmr_val = SETUP_LD;
                    end else begin
                        st_d = ST_DONE;
                    end
                end
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transfer context and read assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            dev_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            pend_q  <= '0;
            lane_q  <= '0;
        end else begin
            if (take) begin
                wr_q    <= h_write;
                addr_q  <= h_waddr[UPA_W-1:0];
                dev_q   <= h_waddr[UPA_W +: DEV_W];
                wdata_q <= h_wdata;
                rdata_q <= '0;
                pend_q  <= h_be;
                lane_q  <= pick_idx;
            end
            if (adv) begin
                pend_q <= pend_q & ~lane_oh;
                lane_q <= pick_idx;
            end
            if (capture) begin
                rdata_q[{lane_q, 3'b000} +: 8] <= ext_din;
            end
        end
    end

    // outputs
    always_comb begin
        active   = (st_q == ST_SETUP) || (st_q == ST_STROBE) || (st_q == ST_HOLD);
        ext_cs_n = active ? ~(NDEV'(1) << dev_q) : '1;
        ext_rd_n = !((st_q == ST_STROBE) && !wr_q);
        ext_wr_n = !((st_q == ST_STROBE) && wr_q);
        ext_doe  = active && wr_q;
        ext_dout = wdata_q[{lane_q, 3'b000} +: 8];
        ext_addr = {addr_q, lane_q};
        h_rdata  = rdata_q;
        h_wait   = req && (st_q != ST_DONE);
    end

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));

    p_addr_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ext_rd_n || !ext_wr_n) && $past(!ext_rd_n || !ext_wr_n)) |-> $stable(ext_addr));

    p_one_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n));

    p_strobe_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n || !ext_wr_n) |-> (ext_cs_n != '1));

    p_drive_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_doe |-> ext_rd_n);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (!ext_doe && (ext_cs_n == '1)));

    p_lane_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && st_d == ST_SETUP) |=> (lane_q > $past(lane_q)));

    p_skip_cleared_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SETUP) |-> pend_q[lane_q]);

endmodule

// File: tb/tb_wide_byte_bridge.sv
`timescale 1ns/1ps
module tb_wide_byte_bridge;

    localparam int SU = 1;
    localparam int SB = 2;
    localparam int HD = 1;
    localparam int LPB = SU + SB + HD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] h_waddr = '0;
    logic [3:0]  h_be = '0;
    logic        h_read = 1'b0;
    logic        h_write = 1'b0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        h_wait;
    logic [3:0]  h_irq;
    logic [19:0] ext_addr;
    logic [7:0]  ext_dout;
    logic [7:0]  ext_din;
    logic        ext_doe;
    logic        ext_rd_n;
    logic        ext_wr_n;
    logic [3:0]  ext_cs_n;
    logic [3:0]  ext_irq_n = 4'hF;

    int errors = 0;
    int checks = 0;

    wide_byte_bridge #(
        .SETUP_CYC(SU), .STROBE_CYC(SB), .HOLD_CYC(HD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .h_waddr(h_waddr), .h_be(h_be),
        .h_read(h_read), .h_write(h_write), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_wait(h_wait), .h_irq(h_irq),
        .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_din(ext_din),
        .ext_doe(ext_doe), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_cs_n(ext_cs_n), .ext_irq_n(ext_irq_n)
    );

    always #10 clk = ~clk;

    // device model: 64 bytes per device, aliased across the window
    logic [7:0] mem [256];
    logic       cur_wr;
    logic [19:0] cur_wa;
    logic [31:0] cur_wd;
    int  bus_cyc, n_str, last_lane, slen;
    logic [3:0] seen;
    bit  order_bad, addr_bad, data_bad, width_bad, doe_bad, stb_prev;

    function automatic int dev_of(input logic [3:0] cs_n);
        int d = -1;
        for (int i = 0; i < 4; i++) if (!cs_n[i]) d = i;
        return d;
    endfunction

    always_comb begin
        int d;
        d = dev_of(ext_cs_n);
        ext_din = (d >= 0 && !ext_rd_n) ? mem[{d[1:0], ext_addr[5:0]}] : 8'h00;
    end

    always @(negedge clk) begin
        bit stb;
        int ln;
        int d;
        if (rst_n) begin
            stb = !ext_rd_n || !ext_wr_n;
            d = dev_of(ext_cs_n);
            if (ext_cs_n != 4'hF) bus_cyc++;
            if (ext_doe && !cur_wr) doe_bad = 1;
            if (stb && !stb_prev) begin
                n_str++;
                ln = int'(ext_addr[1:0]);
                if (ln <= last_lane) order_bad = 1;
                last_lane = ln;
                seen[ln] = 1'b1;
                if (ext_addr[19:2] != cur_wa[17:0] ||
                    ext_cs_n != ~(4'b0001 << cur_wa[19:18])) addr_bad = 1;
                if (cur_wr && (ext_wr_n || !ext_doe || ext_dout != cur_wd[ln*8 +: 8])) data_bad = 1;
                if (!cur_wr && ext_rd_n) data_bad = 1;
            end
            if (stb) slen++;
            else if (stb_prev) begin
                if (slen != SB) width_bad = 1;
                slen = 0;
            end
            if (!ext_wr_n && d >= 0) mem[{d[1:0], ext_addr[5:0]}] = ext_dout;
            stb_prev = stb;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input logic [19:0] wa, input int ln);
        return mem[{wa[19:18], wa[3:0], ln[1:0]}];
    endfunction

    task automatic xfer(input bit wr, input logic [19:0] wa, input logic [3:0] be, input logic [31:0] wd);
        logic [31:0] exp_r;
        logic [31:0] exp_w;
        logic [31:0] got_w;
        int n;
        int waits;
        n = $countones(be);
        exp_r = '0;
        for (int l = 0; l < 4; l++) begin
            exp_w[l*8 +: 8] = be[l] ? wd[l*8 +: 8] : mbyte(wa, l);
            if (be[l]) exp_r[l*8 +: 8] = mbyte(wa, l);
        end
        @(negedge clk);
        cur_wr = wr; cur_wa = wa; cur_wd = wd;
        bus_cyc = 0; n_str = 0; last_lane = -1; seen = '0; slen = 0;
        order_bad = 0; addr_bad = 0; data_bad = 0; width_bad = 0; doe_bad = 0;
        h_waddr = wa; h_be = be; h_wdata = wd; h_write = wr; h_read = !wr;
        waits = 0;
        forever begin
            @(negedge clk);
            if (!h_wait || waits > 2000) break;
            waits++;
        end
        chk(waits == n * LPB, "R6 wait cycles", waits, n * LPB);
        if (!wr) chk(h_rdata == exp_r, "R7 read lanes", h_rdata, exp_r);
        h_read = 1'b0; h_write = 1'b0;
        chk(n_str == n, "R1 strobe count", n_str, n);
        chk(seen == be, "R1 lanes touched", seen, be);
        chk(!order_bad, "R4 ascending lanes", order_bad, 0);
        chk(!addr_bad, "R2/R3 address and select", addr_bad, 0);
        chk(!width_bad && bus_cyc == n * LPB, "R5 phase timing", bus_cyc, n * LPB);
        chk(!data_bad && !doe_bad, "R8 write data and drive", data_bad, 0);
        if (wr) begin
            for (int l = 0; l < 4; l++) got_w[l*8 +: 8] = mbyte(wa, l);
            chk(got_w == exp_w, "R8 bytes after write", got_w, exp_w);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0B1D));
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
        cur_wr = 0; cur_wa = '0; cur_wd = '0; stb_prev = 0;
        bus_cyc = 0; n_str = 0; last_lane = -1; seen = '0; slen = 0;
        order_bad = 0; addr_bad = 0; data_bad = 0; width_bad = 0; doe_bad = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ext_cs_n == 4'hF && ext_rd_n && ext_wr_n, "R10 reset bus idle", {ext_cs_n, ext_rd_n, ext_wr_n}, 6'h3F);
        chk(!ext_doe && !h_wait && h_irq == 4'h0, "R10 reset host side", {ext_doe, h_wait, h_irq}, 0);

        // directed corners: single lanes, halves, word, empty, split
        for (int l = 0; l < 4; l++) xfer(0, 20'h4_0010 + 20'(l), 4'b0001 << l, 32'h0);
        xfer(0, 20'h8_0003, 4'b0011, 32'h0);
        xfer(0, 20'h8_0003, 4'b1100, 32'h0);
        xfer(1, 20'hC_0005, 4'b1111, 32'hA1B2C3D4);
        xfer(0, 20'hC_0005, 4'b1111, 32'h0);
        xfer(1, 20'h0_0007, 4'b0000, 32'hFFFFFFFF);
        xfer(0, 20'h0_0007, 4'b0000, 32'h0);
        xfer(1, 20'h4_0009, 4'b1001, 32'h11223344);
        xfer(1, 20'h0_000A, 4'b0100, 32'h00EE0000);

        // interrupt synchroniser
        @(negedge clk);
        ext_irq_n = 4'b1010;
        @(negedge clk);
        chk(h_irq == 4'h0, "R9 one edge not yet", h_irq, 0);
        @(negedge clk);
        chk(h_irq == 4'b0101, "R9 after two edges", h_irq, 4'b0101);
        ext_irq_n = 4'hF;

        // random mix
        for (int k = 0; k < 200; k++) begin
            xfer(1'($urandom), 20'($urandom), 4'($urandom), $urandom);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule